// File: doc/BRIEF.md
# SMBus Word-Register Slave

This block is a two-wire bus slave that keeps two 5-bit setting codes, one in a low register and one in a high register. A master loads both with a single word-write transaction: the device address with the direction bit clear, a command byte, then two data bytes. The upper five bits of the first data byte become the low code and the upper five bits of the second become the high code. Both codes are presented on output ports. They change only once the slave acknowledges the second data byte.

A word-read begins in the same way as a word-write, with the address and a command byte. The master then issues a repeated START and sends the address with the direction bit set. The slave returns the low register first. It sends the high register only after the master acknowledges the low byte. Each returned byte carries three fields: the stored 5-bit code in bits 7..3, the converter-off status input in bit 2, and zeros in bits 1..0.

Clock and data are sampled from the system clock through two-flop synchronisers. The slave pulls the data line down by raising an output enable. It never drives the line high.

Top module: `smb_word_slave`

## Requirements
- R1: After reset, `sda_oe` is 0 and both code outputs are 0.
- R2: A word-write to the device address is acknowledged on all four bytes. After the ACK of the second data byte, `code_lo` equals bits 7..3 of the first data byte and `code_hi` equals bits 7..3 of the second. The codes change only while the slave is driving that ACK.
- R3: When a transaction's address byte does not match `DEV_ADDR`, every byte is NACKed and neither code changes.
- R4: A word-read consists of address with bit 0 = 0, a command byte, a repeated START, and address with bit 0 = 1. All three are ACKed. The slave then returns the low register first, MSB first.
- R5: The slave sends the high byte only after the master ACKs the low byte. If the master NACKs the low byte, the slave releases SDA for all further clocks until the next START.
- R6: Bit 2 of each returned byte equals `conv_off_i` (1 = off, 0 = on) as sampled when that byte begins. The value can therefore differ between the two bytes.
- R7: Bits 1..0 of every returned byte are 0.
- R8: A STOP or START that arrives before the ACK of the second data byte aborts the write, and neither code changes.
- R9: A read address that follows a fresh START, with no command byte before it, is NACKed.
- R10: `sda_oe` changes only while SCL is low. It is 0 whenever the slave is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| conv_off_i | input | 1 | Converter status, 1 when off; packed into bit 2 of read bytes |
| sda_oe | output | 1 | 1 pulls the data line low |
| code_lo | output | 5 | Stored low-register code |
| code_hi | output | 5 | Stored high-register code |

## Verification
Two events can fall within a single SCL period: the commit of a word-write at its final ACK, and a repeated START that begins a read-back immediately afterwards, with no STOP between them. The bench provokes this by chaining a write directly into a read. The read must return the codes just written, and it must be accepted only because the command byte of the new transaction arms it.

A second collision occurs when `conv_off_i` flips during the master's ACK of the low byte. At that moment the slave is loading the high byte. The bench's model expects the new status value in the high byte only, and it judges both bytes bit by bit on every SCL high phase.

// File: rtl/smb_word_slave.sv
`timescale 1ns/1ps
module smb_word_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h3A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       conv_off_i,
  output logic       sda_oe,
  output logic [4:0] code_lo,
  output logic [4:0] code_hi
);
  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACKO, S_TX, S_ACKI} phase_t;
  typedef enum logic [2:0] {B_ADDR, B_CMD, B_DLO, B_DHI, B_RLO, B_RHI} stage_t;

  logic [1:0] scl_m, sda_m;
  logic       scl_q, sda_q;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, bus_start, bus_stop;

  phase_t     phase;
  stage_t     stage;
  logic [2:0] bcnt;
  logic [7:0] sh;
  logic [4:0] lo_hold;
  logic       full, cmd_seen, rd_arm, mack;

  assign scl_s     = scl_m[1];
  assign sda_s     = sda_m[1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 2'b11;
      sda_m <= 2'b11;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_m <= {scl_m[0], scl_i};
      sda_m <= {sda_m[0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= S_IDLE;
      stage    <= B_ADDR;
      bcnt     <= '0;
      sh       <= '0;
      lo_hold  <= '0;
      full     <= 1'b0;
      cmd_seen <= 1'b0;
      rd_arm   <= 1'b0;
      mack     <= 1'b0;
      sda_oe   <= 1'b0;
      code_lo  <= '0;
      code_hi  <= '0;
    end else if (bus_start) begin
      phase    <= S_RX;
      stage    <= B_ADDR;
      bcnt     <= '0;
      full     <= 1'b0;
      sda_oe   <= 1'b0;
      rd_arm   <= cmd_seen;
      cmd_seen <= 1'b0;
    end else if (bus_stop) begin
      phase    <= S_IDLE;
      sda_oe   <= 1'b0;
      cmd_seen <= 1'b0;
      rd_arm   <= 1'b0;
    end else begin
      case (phase)
        S_RX: begin
          if (scl_rise) begin
            sh   <= {sh[6:0], sda_s};
            bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd7) full <= 1'b1;
          end else if (scl_fall && full) begin
            full <= 1'b0;
            case (stage)
              B_ADDR: begin
                if (sh[7:1] == DEV_ADDR && (!sh[0] || rd_arm)) begin
                  phase  <= S_ACKO;
                  sda_oe <= 1'b1;
                  stage  <= sh[0] ? B_RLO : B_CMD;
                end else begin
                  phase <= S_IDLE;
                end
              end
              B_CMD: begin
                phase    <= S_ACKO;
                sda_oe   <= 1'b1;
                cmd_seen <= 1'b1;
                stage    <= B_DLO;
              end
              B_DLO: begin
                phase    <= S_ACKO;
                sda_oe   <= 1'b1;
                cmd_seen <= 1'b0;
                lo_hold  <= sh[7:3];
                stage    <= B_DHI;
              end
              default: begin
                phase   <= S_ACKO;
                sda_oe  <= 1'b1;
                code_lo <= lo_hold;
                code_hi <= sh[7:3];
                stage   <= B_ADDR;
              end
            endcase
          end
        end
        S_ACKO: begin
          if (scl_fall) begin
            bcnt <= '0;
            if (stage == B_ADDR) begin
              phase  <= S_IDLE;
              sda_oe <= 1'b0;
            end else if (stage == B_RLO) begin
              phase  <= S_TX;
              sh     <= {code_lo, conv_off_i, 2'b00};
              sda_oe <= ~code_lo[4];
            end else begin
              phase  <= S_RX;
              sda_oe <= 1'b0;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (bcnt == 3'd7) begin
              phase  <= S_ACKI;
              sda_oe <= 1'b0;
            end else begin
              sh     <= {sh[6:0], 1'b0};
              sda_oe <= ~sh[6];
              bcnt   <= bcnt + 3'd1;
            end
          end
        end
        S_ACKI: begin
          if (scl_rise) mack <= ~sda_s;
          else if (scl_fall) begin
            bcnt <= '0;
            if (stage == B_RLO && mack) begin
              stage  <= B_RHI;
              phase  <= S_TX;
              sh     <= {code_hi, conv_off_i, 2'b00};
              sda_oe <= ~code_hi[4];
            end else begin
              phase <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smb_word_slave_chk.sv
`timescale 1ns/1ps
module smb_word_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic [2:0] phase,
  input logic [2:0] bcnt,
  input logic       sda_oe,
  input logic [4:0] code_lo,
  input logic [4:0] code_hi
);
  p_stable_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  p_idle_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd0) |-> !sda_oe);

  p_commit_on_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({code_lo, code_hi}) |-> sda_oe);

  p_zero_lsbs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd3 && bcnt >= 3'd6) |-> sda_oe);

  p_codes_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 3'd1) |=> $stable({code_lo, code_hi}));
endmodule

bind smb_word_slave smb_word_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .phase(phase), .bcnt(bcnt),
  .sda_oe(sda_oe), .code_lo(code_lo), .code_hi(code_hi)
);

// File: tb/test_smb_word_slave.sv
`timescale 1ns/1ps
module test_smb_word_slave;
  localparam int H = 10;
  localparam logic [6:0] A = 7'h3A;

  logic clk = 0, rst_n = 0, scl = 1, m_sda = 1, conv_off = 0;
  logic sda_oe;
  logic [4:0] code_lo, code_hi;
  logic sda;
  assign sda = m_sda & ~sda_oe;

  smb_word_slave #(.DEV_ADDR(A)) i_smb_word_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .conv_off_i(conv_off),
    .sda_oe(sda_oe), .code_lo(code_lo), .code_hi(code_hi));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, settle = 0;
  bit done = 0, mon_en = 0;
  logic exp_oe = 0;
  logic [4:0] m_lo = 0, m_hi = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always begin
    @(negedge clk); #1;
    if (mon_en) begin
      if (settle > 0) settle--;
      else chk({code_lo, code_hi} == {m_lo, m_hi}, "R2/R3/R8 codes", {code_lo, code_hi}, {m_lo, m_hi});
      if (scl) chk(sda_oe == exp_oe, "R10 sda_oe while SCL high", sda_oe, exp_oe);
    end
  end

  function automatic logic [7:0] pack(input logic [4:0] c, input logic off);
    return {c, off, 2'b00};
  endfunction

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic m, input logic e, output logic r);
    m_sda = m; wt(H);
    exp_oe = e; scl = 1; wt(H/2);
    r = sda; wt(H - H/2);
    scl = 0; exp_oe = 0;
  endtask

  task automatic start_c();
    exp_oe = 0; m_sda = 1; wt(H); scl = 1; wt(H); m_sda = 0; wt(H); scl = 0; wt(H);
  endtask

  task automatic stop_c();
    exp_oe = 0; m_sda = 0; wt(H); scl = 1; wt(H); m_sda = 1; wt(H);
  endtask

  task automatic byte_out(input logic [7:0] b, input logic ack_exp, input string req,
                          input bit commit, input logic [4:0] nlo, input logic [4:0] nhi);
    logic r;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], 1'b0, r);
    if (commit) begin m_lo = nlo; m_hi = nhi; settle = 6; end
    bit_cycle(1'b1, ack_exp, r);
    chk(r == ~ack_exp, req, r, ~ack_exp);
  endtask

  task automatic byte_in(input logic [7:0] exp, input logic ack, input bit flip, input string req);
    logic r;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, ~exp[i], r);
      got[i] = r;
    end
    if (flip) conv_off = ~conv_off;
    bit_cycle(~ack, 1'b0, r);
    chk(got == exp, req, got, exp);
  endtask

  task automatic write_word(input logic [7:0] cmd, input logic [7:0] d0, input logic [7:0] d1);
    start_c();
    byte_out({A, 1'b0}, 1, "R2 write address ACK", 0, 0, 0);
    byte_out(cmd, 1, "R2 command ACK", 0, 0, 0);
    byte_out(d0, 1, "R2 low data ACK", 0, 0, 0);
    byte_out(d1, 1, "R2 high data ACK", 1, d0[7:3], d1[7:3]);
  endtask

  task automatic read_word(input bit flip, input bit pre_start);
    logic [7:0] e;
    if (pre_start) start_c();
    byte_out({A, 1'b0}, 1, "R4 address ACK", 0, 0, 0);
    byte_out(8'h10, 1, "R4 command ACK", 0, 0, 0);
    start_c();
    byte_out({A, 1'b1}, 1, "R4 read address ACK", 0, 0, 0);
    e = pack(m_lo, conv_off);
    byte_in(e, 1, flip, "R4/R6/R7 low byte");
    e = pack(m_hi, conv_off);
    byte_in(e, 0, 0, "R5/R6/R7 high byte");
    stop_c();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic r;
    wt(5);
    chk(sda_oe == 0, "R1 sda_oe reset", sda_oe, 0);
    chk(code_lo == 0, "R1 code_lo reset", code_lo, 0);
    chk(code_hi == 0, "R1 code_hi reset", code_hi, 0);
    rst_n = 1; wt(5);
    mon_en = 1;

    write_word(8'h10, 8'hA8, 8'h5F); stop_c();
    chk(code_lo == 5'h15 && code_hi == 5'h0B, "R2 codes after write", {code_lo, code_hi}, {5'h15, 5'h0B});
    read_word(0, 1);
    conv_off = 1; read_word(0, 1);
    read_word(1, 1);

    // R3: wrong address
    start_c();
    byte_out({7'h3B, 1'b0}, 0, "R3 wrong address NACK", 0, 0, 0);
    byte_out(8'h10, 0, "R3 command ignored", 0, 0, 0);
    byte_out(8'h00, 0, "R3 data ignored", 0, 0, 0);
    byte_out(8'h00, 0, "R3 data ignored", 0, 0, 0);
    stop_c();

    // R8: STOP after low data byte
    start_c();
    byte_out({A, 1'b0}, 1, "R8 address ACK", 0, 0, 0);
    byte_out(8'h10, 1, "R8 command ACK", 0, 0, 0);
    byte_out(8'h00, 1, "R8 low data ACK", 0, 0, 0);
    stop_c();
    // R8: START inside the high data byte
    start_c();
    byte_out({A, 1'b0}, 1, "R8 address ACK", 0, 0, 0);
    byte_out(8'h10, 1, "R8 command ACK", 0, 0, 0);
    byte_out(8'h00, 1, "R8 low data ACK", 0, 0, 0);
    for (int i = 0; i < 4; i++) bit_cycle(1'b0, 1'b0, r);
    start_c(); stop_c();
    chk(code_lo == 5'h15 && code_hi == 5'h0B, "R8 codes after abort", {code_lo, code_hi}, {5'h15, 5'h0B});
    conv_off = 0; read_word(0, 1);

    // R9: read address with no command
    start_c();
    byte_out({A, 1'b1}, 0, "R9 bare read NACK", 0, 0, 0);
    for (int i = 0; i < 9; i++) bit_cycle(1'b1, 1'b0, r);
    stop_c();

    // R5: master NACKs the low byte
    start_c();
    byte_out({A, 1'b0}, 1, "R5 address ACK", 0, 0, 0);
    byte_out(8'h10, 1, "R5 command ACK", 0, 0, 0);
    start_c();
    byte_out({A, 1'b1}, 1, "R5 read address ACK", 0, 0, 0);
    byte_in(pack(m_lo, conv_off), 0, 0, "R5 low byte");
    for (int i = 0; i < 9; i++) begin
      bit_cycle(1'b1, 1'b0, r);
      chk(r == 1'b1, "R5 SDA released after NACK", r, 1);
    end
    stop_c();

    // Write chained straight into read via repeated START
    write_word(8'h22, 8'hFF, 8'h07);
    start_c();
    read_word(0, 0);
    chk(code_lo == 5'h1F && code_hi == 5'h00, "R2 boundary codes", {code_lo, code_hi}, {5'h1F, 5'h00});

    wt(20);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule